// File: doc/BRIEF.md
# Transmit Queue Start/Stop Controller

This block holds the run state of a set of transmit queues. Software starts a queue by writing a one to that queue's bit in the start register. It asks for a stop by writing a one to the queue's bit in the stop register. The stop does not take effect at once. The queue keeps reporting itself as running until every frame it still holds has left. Only then does its running bit drop.

Each queue keeps a count of frames that are waiting. The count rises on an enqueue pulse and falls on a completion pulse. A per-queue flush option makes a stopping queue throw away its waiting frames, one per cycle, so the stop completes quickly. Each queue also has a descriptor-pointer register. A write to that register is refused while the queue is running, and the refusal is recorded in a sticky error bit.

Frame fetch, medium access and the host bus are outside the block. Enqueue and completion arrive as plain pulses, and the registers are written through simple strobe-and-data ports.

Top module: `txq_ctrl`

## Requirements
- R1: After reset, the following all read zero: every running bit, every stop bit, every flush bit, every pending count, every pointer, every error bit and every discard strobe.
- R2: A write on the start port sets `run_o[i]` on the next clock for each queue i (bit i of the data) whose data bit is 1 and whose stop bit is clear. Data bits that are 0 leave their queues unchanged.
- R3: A start request is ignored for any queue whose stop bit is set at the time of the write.
- R4: A stop-port write with non-zero data ORs its ones into `stop_o` on the next clock. A stop-port write of all zeros clears every stop bit.
- R5: While a queue's stop bit is set and its pending count is non-zero, its running bit stays 1. The running bit drops on the clock that follows a cycle in which the stop bit is set and the count is zero.
- R6: Queue i's pending count sits at bits [8i+7:8i] of `pend_o`. It rises by one on an enqueue pulse and falls by one on a completion pulse. It is unchanged when both pulses arrive in the same cycle.
- R7: The pending count holds at 255 when it would overflow, and holds at 0 when it would underflow.
- R8: When a queue's flush bit is set, its stop bit is set and its count is non-zero, `discard_o[i]` is high in that cycle and the count falls by one on the next clock. Without the flush bit, a stopping queue discards nothing.
- R9: A pointer write to a queue whose running bit is clear stores the data. The stored value is visible at bits [32i+31:32i] of `ptr_o` on the next clock.
- R10: A pointer write to a running queue leaves every pointer unchanged and sets that queue's bit in `ptr_err_o`. The error bit stays set until reset.
- R11: A pointer write whose queue select is 10 or greater changes no pointer and no error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_wr | input | 1 | Write strobe for the start register |
| start_data | input | 10 | Queues to start (one bit per queue) |
| stop_wr | input | 1 | Write strobe for the stop register |
| stop_data | input | 10 | Queues to stop; all zeros clears every stop |
| flush_wr | input | 1 | Write strobe for the flush-option register |
| flush_data | input | 10 | New flush-option bits |
| enq_i | input | 10 | Per-queue enqueue pulses |
| cmpl_i | input | 10 | Per-queue completion pulses |
| ptr_wr | input | 1 | Descriptor-pointer write strobe |
| ptr_sel | input | 4 | Queue addressed by the pointer write |
| ptr_data | input | 32 | Pointer value to write |
| run_o | output | 10 | Running bit per queue |
| stop_o | output | 10 | Pending stop request per queue |
| flush_o | output | 10 | Flush option per queue |
| discard_o | output | 10 | Frame discarded this cycle, per queue |
| pend_o | output | 80 | Pending counts, 8 bits per queue |
| ptr_o | output | 320 | Descriptor pointers, 32 bits per queue |
| ptr_err_o | output | 10 | Sticky refused-pointer-write flags |

## Verification
The bench builds the block with its default parameters: ten queues, 8-bit counts and 32-bit pointers. With an 8-bit count, saturation at 255 is reached after a few hundred enqueue pulses, so the overflow boundary is exercised directly. Ten queues in a 4-bit select leave six select codes out of range, which lets the bench test ignored pointer writes. Stops are run both with and without the flush option, so both the slow drain and the per-cycle discard drain are observed.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int unsigned TXQ_NUM_Q_DEF = 10;
    localparam int unsigned TXQ_CNT_W_DEF = 8;
    localparam int unsigned TXQ_PTR_W_DEF = 32;

    // Width of a queue select able to address n queues.
    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/txq_lane.sv
module txq_lane #(
    parameter int unsigned CNT_W = txq_pkg::TXQ_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_set_i,
    input  logic             stop_clr_i,
    input  logic             flush_wr_i,
    input  logic             flush_val_i,
    input  logic             enq_i,
    input  logic             cmpl_i,
    output logic             run_o,
    output logic             stop_o,
    output logic             flush_o,
    output logic             disc_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             run;
        logic             stop;
        logic             flush;
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t lane_d, lane_q;
    logic  empty, disc, dec;

    always_comb begin
        empty  = (lane_q.cnt == '0);
        disc   = lane_q.stop & lane_q.flush & ~empty;
        dec    = (cmpl_i | disc) & ~empty;
        lane_d = lane_q;

        if (stop_clr_i)      lane_d.stop = 1'b0;
        else if (stop_set_i) lane_d.stop = 1'b1;

        if (flush_wr_i) lane_d.flush = flush_val_i;

        if (lane_q.stop && empty)          lane_d.run = 1'b0;
        else if (start_i && !lane_q.stop)  lane_d.run = 1'b1;

        if (enq_i && dec)                       lane_d.cnt = lane_q.cnt;
        else if (enq_i && lane_q.cnt != CNT_MAX) lane_d.cnt = lane_q.cnt + 1'b1;
        else if (dec)                            lane_d.cnt = lane_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign run_o   = lane_q.run;
    assign stop_o  = lane_q.stop;
    assign flush_o = lane_q.flush;
    assign disc_o  = disc;
    assign cnt_o   = lane_q.cnt;

    assert_start_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !run_o) |=> !run_o);
    assert_run_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> ($past(stop_o) && $past(cnt_o) == '0));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && enq_i && !cmpl_i && !disc_o) |=> cnt_o == CNT_MAX);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && !enq_i) |=> cnt_o == '0);
    assert_discard_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |-> (flush_o && stop_o && cnt_o != '0));
endmodule

// File: rtl/txq_ptr_bank.sv
module txq_ptr_bank #(
    parameter int unsigned NUM_Q  = txq_pkg::TXQ_NUM_Q_DEF,
    parameter int unsigned PTR_W  = txq_pkg::TXQ_PTR_W_DEF,
    parameter int unsigned QSEL_W = txq_pkg::sel_width(NUM_Q)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [QSEL_W-1:0]      sel_i,
    input  logic [PTR_W-1:0]       data_i,
    input  logic [NUM_Q-1:0]       active_i,
    output logic [NUM_Q*PTR_W-1:0] ptr_o,
    output logic [NUM_Q-1:0]       err_o
);
    typedef struct packed {
        logic [NUM_Q-1:0][PTR_W-1:0] ptr;
        logic [NUM_Q-1:0]            err;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int q = 0; q < NUM_Q; q++) begin
            if (wr_i && 32'(sel_i) == q) begin
                if (active_i[q]) bank_d.err[q] = 1'b1;
                else             bank_d.ptr[q] = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign ptr_o = bank_q.ptr;
    assign err_o = bank_q.err;

    assert_blocked_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && 32'(sel_i) < NUM_Q && active_i[sel_i]) |=> $stable(ptr_o));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_o & $past(err_o)) == $past(err_o)));
    assert_bad_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && 32'(sel_i) >= NUM_Q) |=> ($stable(ptr_o) && $stable(err_o)));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
    parameter int unsigned NUM_Q  = txq_pkg::TXQ_NUM_Q_DEF,
    parameter int unsigned CNT_W  = txq_pkg::TXQ_CNT_W_DEF,
    parameter int unsigned PTR_W  = txq_pkg::TXQ_PTR_W_DEF,
    parameter int unsigned QSEL_W = txq_pkg::sel_width(NUM_Q)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_wr,
    input  logic [NUM_Q-1:0]       start_data,
    input  logic                   stop_wr,
    input  logic [NUM_Q-1:0]       stop_data,
    input  logic                   flush_wr,
    input  logic [NUM_Q-1:0]       flush_data,
    input  logic [NUM_Q-1:0]       enq_i,
    input  logic [NUM_Q-1:0]       cmpl_i,
    input  logic                   ptr_wr,
    input  logic [QSEL_W-1:0]      ptr_sel,
    input  logic [PTR_W-1:0]       ptr_data,
    output logic [NUM_Q-1:0]       run_o,
    output logic [NUM_Q-1:0]       stop_o,
    output logic [NUM_Q-1:0]       flush_o,
    output logic [NUM_Q-1:0]       discard_o,
    output logic [NUM_Q*CNT_W-1:0] pend_o,
    output logic [NUM_Q*PTR_W-1:0] ptr_o,
    output logic [NUM_Q-1:0]       ptr_err_o
);
    logic stop_clr_all;
    assign stop_clr_all = stop_wr && (stop_data == '0);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
        txq_lane #(.CNT_W(CNT_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (start_wr & start_data[q]),
            .stop_set_i  (stop_wr & stop_data[q]),
            .stop_clr_i  (stop_clr_all),
            .flush_wr_i  (flush_wr),
            .flush_val_i (flush_data[q]),
            .enq_i       (enq_i[q]),
            .cmpl_i      (cmpl_i[q]),
            .run_o       (run_o[q]),
            .stop_o      (stop_o[q]),
            .flush_o     (flush_o[q]),
            .disc_o      (discard_o[q]),
            .cnt_o       (pend_o[q*CNT_W +: CNT_W])
        );
    end

    txq_ptr_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .QSEL_W(QSEL_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ptr_wr),
        .sel_i    (ptr_sel),
        .data_i   (ptr_data),
        .active_i (run_o),
        .ptr_o    (ptr_o),
        .err_o    (ptr_err_o)
    );

    assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clr_all |=> stop_o == '0);
    assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !stop_wr) |=> ((run_o | $past(stop_o)) & $past(start_data)) == $past(start_data));
endmodule

// File: tb/txq_ctrl_bench.sv
module txq_ctrl_bench;
    localparam int NQ = 10;
    logic clk = 1'b0, rst_n = 1'b0;
    logic start_wr = 0, stop_wr = 0, flush_wr = 0, ptr_wr = 0;
    logic [NQ-1:0] start_data = '0, stop_data = '0, flush_data = '0, enq = '0, cmpl = '0;
    logic [3:0] ptr_sel = '0;
    logic [31:0] ptr_data = '0;
    logic [NQ-1:0] run, stp, flsh, disc, perr;
    logic [NQ*8-1:0] pend;
    logic [NQ*32-1:0] ptr;
    int n_chk = 0, n_fail = 0;

    always #5ns clk = ~clk;

    txq_ctrl u_txq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_data(start_data),
        .stop_wr(stop_wr), .stop_data(stop_data), .flush_wr(flush_wr), .flush_data(flush_data),
        .enq_i(enq), .cmpl_i(cmpl), .ptr_wr(ptr_wr), .ptr_sel(ptr_sel), .ptr_data(ptr_data),
        .run_o(run), .stop_o(stp), .flush_o(flsh), .discard_o(disc), .pend_o(pend),
        .ptr_o(ptr), .ptr_err_o(perr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cnt(input int q);
        return pend[q*8 +: 8];
    endfunction

    // Each driver applies at a falling edge and returns at the next one,
    // after the register update.
    task automatic idle();
        @(negedge clk);
    endtask
    task automatic wr_start(input logic [NQ-1:0] d);
        start_wr = 1; start_data = d; @(negedge clk); start_wr = 0; start_data = '0;
    endtask
    task automatic wr_stop(input logic [NQ-1:0] d);
        stop_wr = 1; stop_data = d; @(negedge clk); stop_wr = 0; stop_data = '0;
    endtask
    task automatic wr_flush(input logic [NQ-1:0] d);
        flush_wr = 1; flush_data = d; @(negedge clk); flush_wr = 0; flush_data = '0;
    endtask
    task automatic pulse(input logic [NQ-1:0] e, input logic [NQ-1:0] c);
        enq = e; cmpl = c; @(negedge clk); enq = '0; cmpl = '0;
    endtask
    task automatic wr_ptr(input logic [3:0] s, input logic [31:0] d);
        ptr_wr = 1; ptr_sel = s; ptr_data = d; @(negedge clk); ptr_wr = 0; ptr_sel = '0; ptr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 run", 64'(run), 0);
        chk("R1 stop", 64'(stp), 0);
        chk("R1 flush", 64'(flsh), 0);
        chk("R1 discard", 64'(disc), 0);
        chk("R1 pend", 64'(pend), 0);
        chk("R1 ptr zero", 64'(ptr == '0), 1);
        chk("R1 err", 64'(perr), 0);
    endtask

    task automatic t_start();
        wr_start(10'b00_0000_1001);
        chk("R2 start", 64'(run), 64'h009);
        wr_start('0);
        chk("R2 zero write", 64'(run), 64'h009);
    endtask

    task automatic t_stop_reg();
        wr_stop(10'b00_0001_0000);
        chk("R4 set", 64'(stp), 64'h010);
        wr_start(10'b00_0001_0000);
        chk("R3 start ignored", 64'(run), 64'h009);
        wr_stop(10'b00_1000_0000);
        chk("R4 or", 64'(stp), 64'h090);
        wr_stop('0);
        chk("R4 clear all", 64'(stp), 0);
        wr_start(10'b00_0001_0000);
        chk("R2 start after clear", 64'(run), 64'h019);
    endtask

    task automatic t_drain();
        wr_start(10'b00_0000_0010);
        pulse(10'b10, 0);
        pulse(10'b10, 0);
        chk("R6 inc", 64'(cnt(1)), 2);
        pulse(10'b10, 10'b10);
        chk("R6 both", 64'(cnt(1)), 2);
        wr_stop(10'b10);
        chk("R8 no flush no discard", 64'(disc), 0);
        idle(); idle(); idle();
        chk("R5 held", 64'(run[1]), 1);
        chk("R5 count kept", 64'(cnt(1)), 2);
        pulse(0, 10'b10);
        chk("R6 dec", 64'(cnt(1)), 1);
        pulse(0, 10'b10);
        chk("R5 still running at zero", 64'(run[1]), 1);
        idle();
        chk("R5 stopped", 64'(run[1]), 0);
        wr_stop('0);
    endtask

    task automatic t_sat();
        enq = 10'b00_0010_0000;
        for (int i = 0; i < 260; i++) @(negedge clk);
        enq = '0;
        chk("R7 saturate", 64'(cnt(5)), 255);
        pulse(10'b00_0010_0000, 10'b00_0010_0000);
        chk("R7 both at max", 64'(cnt(5)), 255);
        pulse(0, 10'b00_0010_0000);
        chk("R7 dec from max", 64'(cnt(5)), 254);
        pulse(0, 10'b00_0100_0000);
        chk("R7 no underflow", 64'(cnt(6)), 0);
    endtask

    task automatic t_early();
        wr_flush(10'b100);
        chk("R8 flush reg", 64'(flsh), 64'h004);
        wr_start(10'b100);
        pulse(10'b100, 0); pulse(10'b100, 0); pulse(10'b100, 0);
        chk("R6 count 3", 64'(cnt(2)), 3);
        wr_stop(10'b100);
        chk("R8 discard strobe", 64'(disc), 64'h004);
        idle();
        chk("R8 one per cycle", 64'(cnt(2)), 2);
        idle(); idle();
        chk("R8 drained", 64'(cnt(2)), 0);
        chk("R5 run at drain", 64'(run[2]), 1);
        chk("R8 strobe off", 64'(disc), 0);
        idle();
        chk("R5 run dropped", 64'(run[2]), 0);
        wr_stop('0);
        wr_flush('0);
    endtask

    task automatic t_ptr();
        logic [NQ*32-1:0] snap;
        wr_ptr(4'd9, 32'hDEAD_BEEF);
        chk("R9 store", 64'(ptr[9*32 +: 32]), 64'hDEAD_BEEF);
        wr_ptr(4'd0, 32'h1234_5678);
        chk("R10 dropped", 64'(ptr[0 +: 32]), 0);
        chk("R10 err", 64'(perr), 64'h001);
        snap = ptr;
        wr_ptr(4'd12, 32'hFFFF_FFFF);
        chk("R11 ptr unchanged", 64'(ptr == snap), 1);
        chk("R11 err unchanged", 64'(perr), 64'h001);
        idle(); idle();
        chk("R10 sticky", 64'(perr), 64'h001);
    endtask

    initial begin
        #2_000_000ns;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_start();
        t_stop_reg();
        t_drain();
        t_sat();
        t_early();
        t_ptr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule